// File: doc/BRIEF.md
# Dual-Channel Sample Router

This block sits between a two-channel data converter and the logic that produces and consumes its samples. On the capture side it takes two incoming sample streams, A and B, and steers them to two outgoing channels. A mode selects one of three routings. The streams can pass straight through, they can be crossed over, or they can be merged so that both streams leave on outgoing channel A as one alternating stream.

On the playback side it drives two latched converter channels, each with a one-cycle update strobe. In dual mode the two channels are fed by two independent streams, and each channel updates only when its own stream delivers a sample. In interleaved mode a single stream carries I and Q samples in alternation. The block splits that stream so that channel 1 receives the I samples and channel 2 receives the Q samples, and both channels change together once a full pair has arrived.

Every stream uses a valid/ready handshake. The sample width is a parameter, with a default of 14 bits. Mode changes on either side take effect only at a pair boundary, so the two halves of a pair are never split across modes.

Top module: `dual_sample_router`

## Requirements
- R1: With `rx_mode` = 0 (straight), or with the reserved value 3, outgoing A carries incoming A and outgoing B carries incoming B. The data, valid and ready signals pass through combinationally.
- R2: With `rx_mode` = 1 (swap), outgoing B carries incoming A and outgoing A carries incoming B. The ready signals are crossed in the same way.
- R3: With `rx_mode` = 2 (merge), outgoing A presents A1, B1, A2, B2 and so on. Only the input whose turn it is sees ready; the other input sees ready low. A stall on outgoing A holds the current turn.
- R4: While merge routing is active, outgoing B has valid low and data zero.
- R5: With `tx_interleave` = 0 (dual), channel 1 latches `tx_p_data` on each accepted primary sample and channel 2 latches `tx_s_data` on each accepted secondary sample. The two channels update independently, and each strobe pulses in the cycle after its sample is accepted.
- R6: With `tx_interleave` = 1, the primary stream carries I then Q. Accepting an I sample leaves both channels unchanged. Accepting the following Q sample loads channel 1 with that I and channel 2 with that Q in the same cycle, and both strobes pulse together.
- R7: In interleaved mode `tx_s_ready` is low and the secondary input has no effect on either channel. The pair phase starts at I after reset.
- R8: A change of `rx_mode` requested while a merged pair is half sent does not take effect until the B half of that pair has been handed off.
- R9: A change of `tx_interleave` takes one cycle. In that cycle both transmit readies are low, any held unpaired I sample is discarded, and the phase returns to I.
- R10: After reset both converter channels are zero and neither update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 2 | Capture routing: 0 straight, 1 swap, 2 merge, 3 straight |
| tx_interleave | input | 1 | Playback mode: 0 dual, 1 interleaved |
| rx_a_data | input | W | Incoming stream A sample |
| rx_a_valid | input | 1 | Incoming A valid |
| rx_a_ready | output | 1 | Incoming A ready |
| rx_b_data | input | W | Incoming stream B sample |
| rx_b_valid | input | 1 | Incoming B valid |
| rx_b_ready | output | 1 | Incoming B ready |
| out_a_data | output | W | Outgoing channel A sample |
| out_a_valid | output | 1 | Outgoing A valid |
| out_a_ready | input | 1 | Outgoing A ready |
| out_b_data | output | W | Outgoing channel B sample |
| out_b_valid | output | 1 | Outgoing B valid |
| out_b_ready | input | 1 | Outgoing B ready |
| tx_p_data | input | W | Primary playback stream (channel 1, or the I/Q stream) |
| tx_p_valid | input | 1 | Primary valid |
| tx_p_ready | output | 1 | Primary ready |
| tx_s_data | input | W | Secondary playback stream (channel 2 in dual mode) |
| tx_s_valid | input | 1 | Secondary valid |
| tx_s_ready | output | 1 | Secondary ready |
| dac1_data | output | W | Latched channel 1 value |
| dac1_upd | output | 1 | Channel 1 update strobe |
| dac2_data | output | W | Latched channel 2 value |
| dac2_upd | output | 1 | Channel 2 update strobe |

## Verification
The hardest situations to reach are a mode change that arrives in the middle of a pair.

On the capture side, the bench hands off the A half of a merged pair and then requests straight routing. It then confirms that B still has to come out on outgoing A before straight routing takes over.

On the playback side, the bench sends one lone I sample and then toggles the mode away and back. It then sends a fresh I/Q pair and checks that the channels receive that pair and not the stale I.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    RX_STRAIGHT = 2'd0,
    RX_SWAP     = 2'd1,
    RX_MERGE    = 2'd2,
    RX_RSVD     = 2'd3
  } rx_route_e;
endpackage

// File: rtl/dsr_rx_route.sv
module dsr_rx_route
  import dsr_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_req,
  input  logic [W-1:0] a_data,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] b_data,
  input  logic         b_valid,
  output logic         b_ready,
  output logic [W-1:0] oa_data,
  output logic         oa_valid,
  input  logic         oa_ready,
  output logic [W-1:0] ob_data,
  output logic         ob_valid,
  input  logic         ob_ready
);
  rx_route_e mode_q, mode_d;
  logic      turn_b_q, turn_b_d;
  logic      oa_fire;

  always_comb begin
    a_ready  = 1'b0;
    b_ready  = 1'b0;
    oa_data  = '0;
    oa_valid = 1'b0;
    ob_data  = '0;
    ob_valid = 1'b0;
    unique case (mode_q)
      RX_SWAP: begin
        oa_data = b_data; oa_valid = b_valid; b_ready = oa_ready;
        ob_data = a_data; ob_valid = a_valid; a_ready = ob_ready;
      end
      RX_MERGE: begin
        if (turn_b_q) begin
          oa_data = b_data; oa_valid = b_valid; b_ready = oa_ready;
        end else begin
          oa_data = a_data; oa_valid = a_valid; a_ready = oa_ready;
        end
      end
      default: begin
        oa_data = a_data; oa_valid = a_valid; a_ready = oa_ready;
        ob_data = b_data; ob_valid = b_valid; b_ready = ob_ready;
      end
    endcase
  end

  assign oa_fire = oa_valid && oa_ready;

  always_comb begin
    turn_b_d = 1'b0;
    if (mode_q == RX_MERGE) turn_b_d = oa_fire ? !turn_b_q : turn_b_q;
    mode_d = mode_q;
    if (!turn_b_d) mode_d = rx_route_e'(mode_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RX_STRAIGHT;
      turn_b_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      turn_b_q <= turn_b_d;
    end
  end

  // R3
  merge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RX_MERGE) |-> $onehot0({a_ready, b_ready}));
  // R4
  merge_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RX_MERGE) |-> (!ob_valid && ob_data == '0));
  // R8
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_b_q && !(b_valid && oa_ready)) |=> (mode_q == RX_MERGE));
endmodule

// File: rtl/dsr_tx_route.sv
module dsr_tx_route #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         il_req,
  input  logic [W-1:0] p_data,
  input  logic         p_valid,
  output logic         p_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_valid,
  output logic         s_ready,
  output logic [W-1:0] ch1_data,
  output logic         ch1_upd,
  output logic [W-1:0] ch2_data,
  output logic         ch2_upd
);
  logic         il_q, il_d;
  logic         ph_q, ph_d;
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] ch1_q, ch1_d, ch2_q, ch2_d;
  logic         u1_q, u1_d, u2_q, u2_d;
  logic         switching, p_fire, s_fire;

  assign switching = (il_req != il_q);
  assign p_ready   = !switching;
  assign s_ready   = !switching && !il_q;
  assign p_fire    = p_valid && p_ready;
  assign s_fire    = s_valid && s_ready;

  always_comb begin
    il_d   = il_q;
    ph_d   = ph_q;
    hold_d = hold_q;
    ch1_d  = ch1_q;
    ch2_d  = ch2_q;
    u1_d   = 1'b0;
    u2_d   = 1'b0;
    if (switching) begin
      il_d = il_req;
      ph_d = 1'b0;
    end else if (il_q) begin
      if (p_fire && !ph_q) begin
        hold_d = p_data;
        ph_d   = 1'b1;
      end else if (p_fire) begin
        ch1_d = hold_q;
        ch2_d = p_data;
        u1_d  = 1'b1;
        u2_d  = 1'b1;
        ph_d  = 1'b0;
      end
    end else begin
      if (p_fire) begin ch1_d = p_data; u1_d = 1'b1; end
      if (s_fire) begin ch2_d = s_data; u2_d = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q   <= 1'b0;
      ph_q   <= 1'b0;
      hold_q <= '0;
      ch1_q  <= '0;
      ch2_q  <= '0;
      u1_q   <= 1'b0;
      u2_q   <= 1'b0;
    end else begin
      il_q <= il_d;
      ph_q <= ph_d;
      u1_q <= u1_d;
      u2_q <= u2_d;
      if (!switching && il_q && p_fire && !ph_q) hold_q <= hold_d;
      if (u1_d) ch1_q <= ch1_d;
      if (u2_d) ch2_q <= ch2_d;
    end
  end

  assign ch1_data = ch1_q;
  assign ch2_data = ch2_q;
  assign ch1_upd  = u1_q;
  assign ch2_upd  = u2_q;

  // R6
  pair_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (il_q && !switching && ph_q && p_valid) |=> (ch1_upd && ch2_upd));
  // R7
  sec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (il_q && !switching) |=> !ch2_upd || ch1_upd);
  // R9
  switch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switching |=> (!ph_q && !ch1_upd && !ch2_upd));
endmodule

// File: rtl/dual_sample_router.sv
module dual_sample_router #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   rx_mode,
  input  logic         tx_interleave,
  input  logic [W-1:0] rx_a_data,
  input  logic         rx_a_valid,
  output logic         rx_a_ready,
  input  logic [W-1:0] rx_b_data,
  input  logic         rx_b_valid,
  output logic         rx_b_ready,
  output logic [W-1:0] out_a_data,
  output logic         out_a_valid,
  input  logic         out_a_ready,
  output logic [W-1:0] out_b_data,
  output logic         out_b_valid,
  input  logic         out_b_ready,
  input  logic [W-1:0] tx_p_data,
  input  logic         tx_p_valid,
  output logic         tx_p_ready,
  input  logic [W-1:0] tx_s_data,
  input  logic         tx_s_valid,
  output logic         tx_s_ready,
  output logic [W-1:0] dac1_data,
  output logic         dac1_upd,
  output logic [W-1:0] dac2_data,
  output logic         dac2_upd
);
  dsr_rx_route #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode_req(rx_mode),
    .a_data(rx_a_data), .a_valid(rx_a_valid), .a_ready(rx_a_ready),
    .b_data(rx_b_data), .b_valid(rx_b_valid), .b_ready(rx_b_ready),
    .oa_data(out_a_data), .oa_valid(out_a_valid), .oa_ready(out_a_ready),
    .ob_data(out_b_data), .ob_valid(out_b_valid), .ob_ready(out_b_ready)
  );

  dsr_tx_route #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .il_req(tx_interleave),
    .p_data(tx_p_data), .p_valid(tx_p_valid), .p_ready(tx_p_ready),
    .s_data(tx_s_data), .s_valid(tx_s_valid), .s_ready(tx_s_ready),
    .ch1_data(dac1_data), .ch1_upd(dac1_upd),
    .ch2_data(dac2_data), .ch2_upd(dac2_upd)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dac1_upd && !dac2_upd));
endmodule

// File: tb/tb_dual_sample_router.sv
module tb_dual_sample_router;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] rx_mode;
  logic tx_interleave;
  logic [W-1:0] rx_a_data, rx_b_data, out_a_data, out_b_data;
  logic rx_a_valid, rx_a_ready, rx_b_valid, rx_b_ready;
  logic out_a_valid, out_a_ready, out_b_valid, out_b_ready;
  logic [W-1:0] tx_p_data, tx_s_data, dac1_data, dac2_data;
  logic tx_p_valid, tx_p_ready, tx_s_valid, tx_s_ready, dac1_upd, dac2_upd;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_sample_router #(.W(W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_a_valid = 0; rx_b_valid = 0; rx_a_data = '0; rx_b_data = '0;
    out_a_ready = 0; out_b_ready = 0;
    tx_p_valid = 0; tx_s_valid = 0; tx_p_data = '0; tx_s_data = '0;
  endtask

  task automatic t_reset();
    chk("R10 dac1", dac1_data, 0);
    chk("R10 dac2", dac2_data, 0);
    chk("R10 upd", {dac1_upd, dac2_upd}, 0);
    chk("R10 outvalid", {out_a_valid, out_b_valid}, 0);
  endtask

  task automatic t_straight(input logic [1:0] m, input string r);
    @(negedge clk); rx_mode = m;
    @(negedge clk);
    rx_a_data = 14'h0AA1; rx_b_data = 14'h0BB1; rx_a_valid = 1; rx_b_valid = 0;
    out_a_ready = 0; out_b_ready = 1; #1;
    chk({r, " a->a data"}, out_a_data, 14'h0AA1);
    chk({r, " a valid"}, out_a_valid, 1);
    chk({r, " b valid"}, out_b_valid, 0);
    chk({r, " readies"}, {rx_a_ready, rx_b_ready}, 2'b01);
  endtask

  task automatic t_swap();
    @(negedge clk); rx_mode = 2'd1;
    @(negedge clk);
    rx_a_data = 14'h1111; rx_b_data = 14'h2222; rx_a_valid = 1; rx_b_valid = 0;
    out_a_ready = 1; out_b_ready = 0; #1;
    chk("R2 outA=inB", out_a_data, 14'h2222);
    chk("R2 outB=inA", out_b_data, 14'h1111);
    chk("R2 valids", {out_a_valid, out_b_valid}, 2'b01);
    chk("R2 readies", {rx_a_ready, rx_b_ready}, 2'b01);
  endtask

  task automatic t_merge();
    @(negedge clk); rx_mode = 2'd2; idle_inputs();
    @(negedge clk);
    rx_a_data = 14'h00A1; rx_b_data = 14'h00B1; rx_a_valid = 1; rx_b_valid = 1;
    out_a_ready = 1; out_b_ready = 1; #1;
    chk("R3 first A1", out_a_data, 14'h00A1);
    chk("R3 ready A only", {rx_a_ready, rx_b_ready}, 2'b10);
    chk("R4 B idle", {out_b_valid, out_b_data}, 0);
    @(negedge clk); rx_a_data = 14'h00A2; #1;
    chk("R3 then B1", out_a_data, 14'h00B1);
    chk("R3 ready B only", {rx_a_ready, rx_b_ready}, 2'b01);
    out_a_ready = 0;
    @(negedge clk); #1;
    chk("R3 stall holds B", out_a_data, 14'h00B1);
    out_a_ready = 1;
    @(negedge clk); rx_b_data = 14'h00B2; #1;
    chk("R3 then A2", out_a_data, 14'h00A2);
    @(negedge clk); #1;
    chk("R3 then B2", out_a_data, 14'h00B2);
    @(negedge clk); #1;
    chk("R3 wraps to A", {rx_a_ready, rx_b_ready}, 2'b10);
  endtask

  task automatic t_defer();
    rx_a_data = 14'h0C01; rx_b_data = 14'h0D01; rx_a_valid = 1; rx_b_valid = 0;
    out_a_ready = 1; out_b_ready = 1;
    @(negedge clk);
    rx_mode = 2'd0; rx_a_valid = 0; #1;
    chk("R8 still merge, B turn", {rx_a_ready, rx_b_ready}, 2'b01);
    chk("R8 outB still idle", out_b_valid, 0);
    @(negedge clk); #1;
    chk("R8 held while B pending", rx_a_ready, 0);
    rx_b_valid = 1;
    @(negedge clk); rx_b_data = 14'h0D02; #1;
    chk("R8 straight after pair", out_b_data, 14'h0D02);
    chk("R8 B valid straight", out_b_valid, 1);
    idle_inputs();
  endtask

  task automatic t_dual();
    @(negedge clk); tx_interleave = 0;
    tx_p_data = 14'h0101; tx_p_valid = 1; tx_s_valid = 0;
    @(negedge clk);
    chk("R5 ch1 load", dac1_data, 14'h0101);
    chk("R5 upd only ch1", {dac1_upd, dac2_upd}, 2'b10);
    tx_p_valid = 0; tx_s_data = 14'h0202; tx_s_valid = 1;
    @(negedge clk);
    chk("R5 ch2 load", dac2_data, 14'h0202);
    chk("R5 ch1 kept", dac1_data, 14'h0101);
    chk("R5 upd only ch2", {dac1_upd, dac2_upd}, 2'b01);
    tx_s_valid = 0;
  endtask

  task automatic t_interleave();
    @(negedge clk); tx_interleave = 1; #1;
    chk("R9 readies low on switch", {tx_p_ready, tx_s_ready}, 0);
    @(negedge clk); #1;
    chk("R7 s_ready low", {tx_p_ready, tx_s_ready}, 2'b10);
    tx_p_data = 14'h0111; tx_p_valid = 1;
    tx_s_data = 14'h3333; tx_s_valid = 1;
    @(negedge clk);
    chk("R6 I alone no upd", {dac1_upd, dac2_upd}, 0);
    chk("R7 sec ignored", dac2_data, 14'h0202);
    tx_p_data = 14'h0222;
    @(negedge clk);
    chk("R6 both upd", {dac1_upd, dac2_upd}, 2'b11);
    chk("R6 ch1=I", dac1_data, 14'h0111);
    chk("R6 ch2=Q", dac2_data, 14'h0222);
    tx_p_valid = 0; tx_s_valid = 0;
  endtask

  task automatic t_discard();
    @(negedge clk); tx_p_data = 14'h0999; tx_p_valid = 1;
    @(negedge clk); tx_p_valid = 0; tx_interleave = 0;
    @(negedge clk); tx_interleave = 1;
    @(negedge clk);
    tx_p_data = 14'h0444; tx_p_valid = 1;
    @(negedge clk);
    chk("R9 fresh I no upd", {dac1_upd, dac2_upd}, 0);
    tx_p_data = 14'h0555;
    @(negedge clk);
    chk("R9 ch1 fresh I", dac1_data, 14'h0444);
    chk("R9 ch2 fresh Q", dac2_data, 14'h0555);
    tx_p_valid = 0;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; rx_mode = 2'd0; tx_interleave = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_straight(2'd0, "R1");
    t_straight(2'd3, "R1 rsvd");
    t_swap();
    t_merge();
    t_defer();
    t_dual();
    t_interleave();
    t_discard();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule